// File: doc/BRIEF.md
# Self-Timed Nonvolatile Write Sequencer

This block performs the internal program and erase cycles of a serial EEPROM model once the command front end has accepted an operation. A one-cycle start pulse comes with an operation code, a start address, a byte count and a page-wide buffer of data. The sequencer captures all of them and then drives the array's write strobe, address and data. It issues one array write per clock, starting in the first busy cycle. For the erase operations every affected byte is written with FFh. Byte and page writes overwrite their target bytes directly and need no earlier erase.

Each operation has its own cycle time, given as a parameter in clock ticks. The busy flag stays high for the longer of two spans: that cycle time, or the number of strobes the operation needs. When the busy flag drops, a one-cycle done pulse follows. A start that arrives while the sequencer is busy is dropped, and so is a start that carries an undefined operation code. The serial protocol, the protection checks and the storage array are handled elsewhere.

Top module: `nvm_write_seq`

## Requirements
- R1: After reset, busy_o, done_o and arr_we_o are all low.
- R2: When start_i is high in a cycle where busy_o is low and op_i is a defined code, busy_o is high in the next cycle. It stays high for exactly max(strobe count, cycle time) cycles.
- R3: The op_i encoding and the cycle times are: 0 byte write (T_WRITE), 1 page write (T_WRITE), 2 page erase (T_PAGE_ERASE), 3 sector erase (T_SECTOR_ERASE) and 4 chip erase (T_CHIP_ERASE).
- R4: A byte write issues exactly one strobe, at addr_i, with data_i[7:0].
- R5: A page write issues len_i strobes, where len_i = 0 means 128. Strobe i writes data_i[8i+7:8i] to address {addr_i[15:7], (addr_i[6:0] + i) mod 128}, so the bytes wrap within the page.
- R6: A page erase writes FFh to all 128 bytes of page addr_i[15:7], in ascending offsets starting at offset 0.
- R7: A sector erase writes FFh to all 16384 bytes of sector addr_i[15:14], in ascending order.
- R8: A chip erase writes FFh to all 65536 addresses, from 0000h upwards.
- R9: While busy, start_i, op_i, addr_i, len_i and data_i have no effect on the strobes, and busy ends on schedule. A start carrying op_i of 5, 6 or 7 leaves busy_o low.
- R10: done_o is high for exactly one cycle, the first cycle after busy_o falls. A start in that cycle is accepted.
- R11: Strobes occur only while busy, in consecutive cycles starting with the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| op_i | input | 3 | Operation code |
| addr_i | input | 16 | Start address |
| len_i | input | 7 | Page-write byte count, 0 meaning 128 |
| data_i | input | 1024 | Write buffer, byte i at bits 8i+7:8i |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 16 | Array address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the end of a cycle and a new start request. The bench raises start_i in the last busy cycle and expects the request to be dropped, so busy_o is low one cycle after the done pulse. It raises start_i again in the done cycle itself and expects the new operation to run with its full strobe sequence. A start in the middle of an operation, together with changed inputs, is also driven, and every strobe is compared with the address and data expected from the original request.

// File: rtl/nvm_write_seq.sv
module nvm_write_seq #(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int PAGE_BYTES     = 128,
  parameter int SECTOR_BYTES   = 16384,
  parameter int T_WRITE        = 100000,
  parameter int T_PAGE_ERASE   = 100000,
  parameter int T_SECTOR_ERASE = 200000,
  parameter int T_CHIP_ERASE   = 200000,
  localparam int LEN_W         = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [2:0]                   op_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [PAGE_BYTES*DATA_W-1:0] data_i,
  output logic                         arr_we_o,
  output logic [ADDR_W-1:0]            arr_addr_o,
  output logic [DATA_W-1:0]            arr_data_o,
  output logic                         busy_o,
  output logic                         done_o
);
  localparam logic [2:0] OP_BYTE = 3'd0, OP_PAGE = 3'd1, OP_PERASE = 3'd2,
                         OP_SERASE = 3'd3, OP_CERASE = 3'd4;

  logic                         busy_q, done_q;
  logic [31:0]                  cyc_q, n_q, tot_q;
  logic [2:0]                   op_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [PAGE_BYTES*DATA_W-1:0] buf_q;
  logic [31:0]                  n_in, t_in;
  logic [ADDR_W-1:0]            mask, off;
  logic                         accept;

  always_comb begin
    n_in = 32'd1;
    t_in = 32'(T_WRITE);
    case (op_i)
      OP_PAGE:   n_in = (len_i == '0) ? 32'(PAGE_BYTES) : 32'(len_i);
      OP_PERASE: begin n_in = 32'(PAGE_BYTES);   t_in = 32'(T_PAGE_ERASE);   end
      OP_SERASE: begin n_in = 32'(SECTOR_BYTES); t_in = 32'(T_SECTOR_ERASE); end
      OP_CERASE: begin n_in = 32'd1 << ADDR_W;   t_in = 32'(T_CHIP_ERASE);   end
      default:   ;
    endcase
  end

  assign accept = start_i && !busy_q && (op_i <= OP_CERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
      n_q    <= '0;
      tot_q  <= '0;
      op_q   <= OP_BYTE;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
        op_q   <= op_i;
        n_q    <= n_in;
        tot_q  <= (n_in > t_in) ? n_in : t_in;
      end else if (busy_q) begin
        if (cyc_q == tot_q - 32'd1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cyc_q <= cyc_q + 32'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= addr_i;
      buf_q  <= data_i;
    end
  end

  always_comb begin
    case (op_q)
      OP_PAGE, OP_PERASE: mask = ADDR_W'(PAGE_BYTES - 1);
      OP_SERASE:          mask = ADDR_W'(SECTOR_BYTES - 1);
      OP_CERASE:          mask = '1;
      default:            mask = '0;
    endcase
  end

  assign off        = (op_q == OP_PAGE) ? addr_q + cyc_q[ADDR_W-1:0] : cyc_q[ADDR_W-1:0];
  assign arr_addr_o = (addr_q & ~mask) | (off & mask);
  assign arr_data_o = (op_q >= OP_PERASE) ? '1 : buf_q[cyc_q[LEN_W-1:0]*DATA_W +: DATA_W];
  assign arr_we_o   = busy_q && (cyc_q < n_q);
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (op_i <= OP_CERASE) |=> busy_o); // R2
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(addr_q) && $stable(op_q)); // R9
  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o && $past(arr_we_o) && (op_q != OP_BYTE) |->
      arr_addr_o[LEN_W-1:0] == $past(arr_addr_o[LEN_W-1:0]) + 1'b1); // R5
endmodule

// File: tb/nvm_write_seq_bench.sv
module nvm_write_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 128;
  localparam int TW = 20, TPE = 100, TSE = 40, TCE = 30;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [15:0] addr_i = '0;
  logic [6:0] len_i = '0;
  logic [PB*8-1:0] data_i = '0;
  logic arr_we_o, busy_o, done_o;
  logic [15:0] arr_addr_o;
  logic [7:0] arr_data_o;

  int n_chk = 0, n_fail = 0, ticks = 0;
  logic [2:0] cur_op;
  logic [15:0] cur_addr;
  logic [6:0] cur_len;
  logic [PB*8-1:0] cur_data;

  nvm_write_seq #(.T_WRITE(TW), .T_PAGE_ERASE(TPE), .T_SECTOR_ERASE(TSE),
                  .T_CHIP_ERASE(TCE)) u_nvm_write_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .len_i(len_i), .data_i(data_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o), .busy_o(busy_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired: actual hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_n(input logic [2:0] op, input logic [6:0] len);
    case (op)
      3'd0: return 1;
      3'd1: return (len == 0) ? PB : int'(len);
      3'd2: return PB;
      3'd3: return 16384;
      default: return 65536;
    endcase
  endfunction

  function automatic int exp_total(input logic [2:0] op, input logic [6:0] len);
    int t;
    case (op)
      3'd0, 3'd1: t = TW;
      3'd2: t = TPE;
      3'd3: t = TSE;
      default: t = TCE;
    endcase
    return (exp_n(op, len) > t) ? exp_n(op, len) : t;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [2:0] op, input logic [15:0] a, input int i);
    logic [15:0] iv;
    iv = 16'(i);
    case (op)
      3'd0: return a;
      3'd1: return {a[15:7], 7'(a[6:0] + iv[6:0])};
      3'd2: return {a[15:7], iv[6:0]};
      3'd3: return {a[15:14], iv[13:0]};
      default: return iv;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input logic [2:0] op, input logic [PB*8-1:0] d, input int i);
    if (op < 3'd2) return d[(i % PB)*8 +: 8];
    return 8'hFF;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [PB*8-1:0] rand_data();
    logic [PB*8-1:0] d;
    for (int w = 0; w < PB/4; w++) d[w*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic drive_start(input logic [2:0] op, input logic [15:0] a, input logic [6:0] len,
                             input logic [PB*8-1:0] d);
    start_i = 1'b1; op_i = op; addr_i = a; len_i = len; data_i = d;
    cur_op = op; cur_addr = a; cur_len = len; cur_data = d;
  endtask

  task automatic observe(input int inj, input logic chain, input logic [2:0] nop,
                         input logic [15:0] na, input logic [6:0] nlen, input logic [PB*8-1:0] nd);
    int k = 0, bad = 0, strobes = 0, nexp, texp;
    logic [31:0] fa = '0, fe = '0;
    nexp = exp_n(cur_op, cur_len);
    texp = exp_total(cur_op, cur_len);
    @(negedge clk);
    while (busy_o && k < 70000) begin
      if (arr_we_o != (k < nexp)) bad++;
      if (arr_we_o) begin
        if (arr_addr_o != exp_addr(cur_op, cur_addr, strobes) ||
            arr_data_o != exp_data(cur_op, cur_data, strobes)) begin
          if (bad == 0) begin
            fa = {8'h0, arr_addr_o, arr_data_o};
            fe = {8'h0, exp_addr(cur_op, cur_addr, strobes), exp_data(cur_op, cur_data, strobes)};
          end
          bad++;
        end
        strobes++;
      end
      if (k == inj) begin
        start_i = 1'b1; op_i = 3'd4; addr_i = ~addr_i; len_i = ~len_i; data_i = ~data_i;
      end else start_i = 1'b0;
      k++;
      @(negedge clk);
    end
    chk(k == texp, "R3 busy length", k, texp);
    chk(strobes == nexp, {op_tag(cur_op), " strobe count"}, strobes, nexp);
    chk(bad == 0, {op_tag(cur_op), " R11 strobe address/data"}, fa, fe);
    chk(done_o == 1'b1, "R10 done after busy", done_o, 1);
    if (chain) drive_start(nop, na, nlen, nd);
    else begin
      start_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b0, (inj >= 0) ? "R9 late start ignored" : "R2 busy low after op", busy_o, 0);
      chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [6:0] len, input int inj);
    drive_start(op, a, len, rand_data());
    observe(inj, 1'b0, 3'd0, 16'd0, 7'd0, '0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && arr_we_o == 0, "R1 reset state",
        {busy_o, done_o, arr_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && arr_we_o == 0, "R1 idle after reset", {busy_o, arr_we_o}, 0);

    run_op(3'd0, 16'h1234, 7'd0, -1);
    run_op(3'd1, 16'h207D, 7'd6, -1);
    run_op(3'd1, 16'h4440, 7'd0, -1);
    run_op(3'd2, 16'hABCD, 7'd0, -1);
    run_op(3'd3, 16'h9F00, 7'd0, -1);
    run_op(3'd1, 16'h00F0, 7'd9, 4);
    run_op(3'd2, 16'h3355, 7'd0, 127);

    for (int opc = 5; opc < 8; opc++) begin
      drive_start(3'(opc), 16'h0100, 7'd3, rand_data());
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 0 && arr_we_o == 0, "R9 undefined op ignored", {busy_o, arr_we_o}, 0);
    end
    @(negedge clk);

    drive_start(3'd1, 16'h7F7E, 7'd5, rand_data());
    observe(19, 1'b1, 3'd0, 16'hBEEF, 7'd0, rand_data());
    observe(-1, 1'b1, 3'd2, 16'h0180, 7'd0, rand_data());
    observe(-1, 1'b0, 3'd0, 16'd0, 7'd0, '0);

    for (int r = 0; r < 12; r++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 2));
      run_op(rop, 16'($urandom), 7'($urandom), ((r % 3) == 0) ? int'($urandom_range(0, 10)) : -1);
    end

    run_op(3'd4, 16'h5A5A, 7'd0, -1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule